// File: doc/BRIEF.md
# I2C Misplaced Bus-Condition Guard

This block sits beside the byte engine of an I2C controller and watches the SCL and SDA lines for START and STOP conditions that arrive where the frame does not allow them. The controller reports its current frame phase and its operating mode. If an illegal condition appears while the controller is a master or an addressed slave, the block records a bus-error status and raises the serial interrupt flag. It then holds both line drivers released until software acknowledges the error.

Software recovers by writing the control register with the stop-request bit set and the interrupt flag cleared. On the following clock the block clears the stop-request bit by itself and leaves the other control bits as they were. It also stops forcing the lines released and pulses a request that returns the controller to its non-addressed slave mode. No STOP condition is put on the bus during recovery: the lines are only let go.

The control bits are plain register fields with a write strobe, and the status and line-release outputs are plain level signals. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `i2c_berr_guard`

## Requirements
- R1: While the interrupt flag `si_o` is 0, `status_o` reads 0xF8. While `si_o` is 1 because of a bus error, it reads 0x00.
- R2: `phase_i` is encoded as 0 idle, 1 address byte, 2 data byte, 3 acknowledge bit and 4 waiting for repeated START. `mode_i` is encoded as 0 non-addressed slave, 1 master and 2 addressed slave. A START or STOP condition seen while `phase_i` is 1, 2 or 3 and `mode_i` is 1 or 2 sets `si_o`. If the line change is applied before clock edge k, `si_o` is set at edge k+2.
- R3: While `mode_i` is 0 (or 3), no bus condition sets `si_o`.
- R4: START and STOP conditions seen while `phase_i` is 0 or 4 (or 5 to 7) are legal and never set `si_o`.
- R5: A START is SDA going from 1 to 0 between two synchronized samples in which SCL is 1 in both. A STOP is the same with SDA going from 0 to 1. An SDA change while SCL is 0, or an SCL change, is not a condition.
- R6: From the edge that sets the error until recovery, `scl_rel_o` and `sda_rel_o` are both 1. Further bus conditions during that time change nothing.
- R7: When an error is pending with `sto_o`=1 and `si_o`=0, the next clock edge does four things: it clears `sto_o`, drops both release outputs to 0, raises `nas_req_o` for exactly one cycle, and keeps `sta_o` and `aa_o` unchanged. No STOP is driven.
- R8: Writing `ctl_si`=1 leaves `si_o` unchanged. Clearing `si_o` without `sto_o` set keeps the error pending with both lines released.
- R9: With no error pending, `sto_o` written to 1 stays 1, and no release or `nas_req_o` activity follows.
- R10: A synchronous active-high `rst` clears `si_o`, `sto_o`, `sta_o`, `aa_o`, `nas_req_o` and both release outputs, so `status_o` reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered SCL line level |
| sda_i | input | 1 | Filtered SDA line level |
| phase_i | input | 3 | Frame phase from the byte engine |
| mode_i | input | 2 | Operating mode from the byte engine |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sta | input | 1 | Written START-request bit |
| ctl_sto | input | 1 | Written STOP-request bit |
| ctl_si | input | 1 | Written interrupt flag (0 clears, 1 no effect) |
| ctl_aa | input | 1 | Written assert-acknowledge bit |
| sta_o | output | 1 | START-request control bit |
| sto_o | output | 1 | STOP-request control bit |
| si_o | output | 1 | Serial interrupt flag |
| aa_o | output | 1 | Assert-acknowledge control bit |
| status_o | output | 8 | Status code |
| scl_rel_o | output | 1 | Force SCL driver released |
| sda_rel_o | output | 1 | Force SDA driver released |
| nas_req_o | output | 1 | One-cycle request to enter non-addressed slave mode |

## Verification
The hardest situation to reach is a condition that lands exactly while the error is pending, and a recovery that is split across separate register writes. The stimulus therefore moves the line pair through deliberate orders. SDA is changed first while SCL is low, and SCL rises afterwards, so that conditions appear only where intended. Extra STARTs and STOPs are injected during the pending error. Software then sets STO and clears SI in separate writes, to show that only the combined state triggers recovery.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ADDR    = 3'd1,
    PH_DATA    = 3'd2,
    PH_ACK     = 3'd3,
    PH_WAIT_RS = 3'd4
  } frame_phase_e;

  typedef enum logic [1:0] {
    MD_NAS = 2'd0,
    MD_MST = 2'd1,
    MD_SLV = 2'd2
  } ctrl_mode_e;

  localparam logic [7:0] STAT_NONE = 8'hF8;
  localparam logic [7:0] STAT_BERR = 8'h00;

  function automatic logic phase_guarded(input logic [2:0] ph);
    return (ph == PH_ADDR) || (ph == PH_DATA) || (ph == PH_ACK);
  endfunction

  function automatic logic mode_active(input logic [1:0] md);
    return (md == MD_MST) || (md == MD_SLV);
  endfunction

endpackage

// File: rtl/i2c_berr_sync.sv
module i2c_berr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b1;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b1;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_berr_cond.sv
module i2c_berr_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // Condition needs SCL high on both samples with SDA moving between them
  assign start_o = scl_p & scl_s &  sda_p & ~sda_s;
  assign stop_o  = scl_p & scl_s & ~sda_p &  sda_s;
endmodule

// File: rtl/i2c_berr_ctl.sv
module i2c_berr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic w_sta,
  input  logic w_sto,
  input  logic w_si,
  input  logic w_aa,
  input  logic hw_set_si,
  input  logic hw_clr_sto,
  output logic sta_o,
  output logic sto_o,
  output logic si_o,
  output logic aa_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sta_o <= 1'b0;
      sto_o <= 1'b0;
      si_o  <= 1'b0;
      aa_o  <= 1'b0;
    end else begin
      if (we) begin
        sta_o <= w_sta;
        aa_o  <= w_aa;
      end
      // hardware clear of STO wins over a coincident write
      if (hw_clr_sto)  sto_o <= 1'b0;
      else if (we)     sto_o <= w_sto;
      // hardware set of SI wins; software may only clear it
      if (hw_set_si)        si_o <= 1'b1;
      else if (we && !w_si) si_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_berr_guard.sv
module i2c_berr_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] phase_i,
  input  logic [1:0] mode_i,
  input  logic       ctl_we,
  input  logic       ctl_sta,
  input  logic       ctl_sto,
  input  logic       ctl_si,
  input  logic       ctl_aa,
  output logic       sta_o,
  output logic       sto_o,
  output logic       si_o,
  output logic       aa_o,
  output logic [7:0] status_o,
  output logic       scl_rel_o,
  output logic       sda_rel_o,
  output logic       nas_req_o
);
  import i2c_berr_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_s;
  logic start_c, stop_c;
  logic err_q, nas_q;
  logic detect, recover;

  assign line_raw = {scl_i, sda_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    i2c_berr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (line_raw[l]),
      .q_o (line_s[l])
    );
  end

  i2c_berr_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (line_s[1]),
    .sda_s   (line_s[0]),
    .start_o (start_c),
    .stop_o  (stop_c)
  );

  assign detect  = (start_c | stop_c) & phase_guarded(phase_i) &
                   mode_active(mode_i) & ~err_q;
  assign recover = err_q & sto_o & ~si_o;

  i2c_berr_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .we         (ctl_we),
    .w_sta      (ctl_sta),
    .w_sto      (ctl_sto),
    .w_si       (ctl_si),
    .w_aa       (ctl_aa),
    .hw_set_si  (detect),
    .hw_clr_sto (recover),
    .sta_o      (sta_o),
    .sto_o      (sto_o),
    .si_o       (si_o),
    .aa_o       (aa_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      nas_q <= 1'b0;
    end else begin
      nas_q <= recover;
      if (recover)     err_q <= 1'b0;
      else if (detect) err_q <= 1'b1;
    end
  end

  assign status_o  = si_o ? STAT_BERR : STAT_NONE;
  assign scl_rel_o = err_q;
  assign sda_rel_o = err_q;
  assign nas_req_o = nas_q;
endmodule

// File: rtl/i2c_berr_guard_chk.sv
module i2c_berr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       detect,
  input logic [1:0] mode_i,
  input logic       ctl_we,
  input logic       sta_o,
  input logic       sto_o,
  input logic       si_o,
  input logic       aa_o,
  input logic [7:0] status_o,
  input logic       scl_rel_o,
  input logic       sda_rel_o,
  input logic       nas_req_o
);
  AST_BERR_RAISES_SI: assert property (@(posedge clk) disable iff (rst)
    detect |=> si_o && status_o == 8'h00 && scl_rel_o && sda_rel_o); // R2
  AST_NAS_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (!si_o && mode_i == 2'd0) |=> !si_o); // R3
  AST_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (scl_rel_o && !(sto_o && !si_o)) |=> scl_rel_o && sda_rel_o); // R6
  AST_RECOVER_STEP: assert property (@(posedge clk) disable iff (rst)
    (scl_rel_o && sto_o && !si_o) |=> !sto_o && !scl_rel_o && !sda_rel_o && nas_req_o); // R7
  AST_NAS_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    nas_req_o |=> !nas_req_o); // R7
  AST_CTL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(sta_o) && $stable(aa_o)); // R7
  AST_SI_NO_SWSET: assert property (@(posedge clk) disable iff (rst)
    (!si_o && !detect) |=> !si_o); // R8
  AST_STO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sto_o && !scl_rel_o && !ctl_we) |=> sto_o && !nas_req_o); // R9
endmodule

bind i2c_berr_guard i2c_berr_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .detect    (detect),
  .mode_i    (mode_i),
  .ctl_we    (ctl_we),
  .sta_o     (sta_o),
  .sto_o     (sto_o),
  .si_o      (si_o),
  .aa_o      (aa_o),
  .status_o  (status_o),
  .scl_rel_o (scl_rel_o),
  .sda_rel_o (sda_rel_o),
  .nas_req_o (nas_req_o)
);

// File: tb/test_i2c_berr_guard.sv
module test_i2c_berr_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1;
  logic [2:0] phase = 3'd0;
  logic [1:0] mode = 2'd0;
  logic we = 1'b0, w_sta = 1'b0, w_sto = 1'b0, w_si = 1'b0, w_aa = 1'b0;
  logic sta_o, sto_o, si_o, aa_o, scl_rel, sda_rel, nas_req;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  int nas_cnt = 0;
  bit started = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  i2c_berr_guard i_i2c_berr_guard (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .phase_i(phase), .mode_i(mode),
    .ctl_we(we), .ctl_sta(w_sta), .ctl_sto(w_sto), .ctl_si(w_si), .ctl_aa(w_aa),
    .sta_o(sta_o), .sto_o(sto_o), .si_o(si_o), .aa_o(aa_o), .status_o(status),
    .scl_rel_o(scl_rel), .sda_rel_o(sda_rel), .nas_req_o(nas_req)
  );

  // behavioural reference model
  logic [1:0] hist[$];
  bit m_err, m_si, m_sto, m_sta, m_aa, m_nas;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_err = 0; m_si = 0; m_sto = 0; m_sta = 0; m_aa = 0; m_nas = 0;
    end else begin
      bit ev, guarded, det, rec;
      ev = hist[0][1] && hist[1][1] && (hist[0][0] != hist[1][0]);
      guarded = (phase >= 3'd1 && phase <= 3'd3) && (mode == 2'd1 || mode == 2'd2);
      det = ev && guarded && !m_err;
      rec = m_err && m_sto && !m_si;
      if (we) begin m_sta = w_sta; m_aa = w_aa; end
      if (rec) m_sto = 0; else if (we) m_sto = w_sto;
      if (det) m_si = 1; else if (we && !w_si) m_si = 0;
      if (rec) m_err = 0; else if (det) m_err = 1;
      m_nas = rec;
      hist.push_back({scl, sda});
      void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R1 status", {24'd0, status}, m_si ? 32'h00 : 32'hF8);
      chk("R2 si", {31'd0, si_o}, {31'd0, m_si});
      chk("R6 scl_rel", {31'd0, scl_rel}, {31'd0, m_err});
      chk("R6 sda_rel", {31'd0, sda_rel}, {31'd0, m_err});
      chk("R7 sto", {31'd0, sto_o}, {31'd0, m_sto});
      chk("R7 sta", {31'd0, sta_o}, {31'd0, m_sta});
      chk("R7 aa", {31'd0, aa_o}, {31'd0, m_aa});
      chk("R7 nas_req", {31'd0, nas_req}, {31'd0, m_nas});
      if (nas_req) nas_cnt++;
    end
  end

  task automatic step(input logic c, input logic d, input int n);
    @(negedge clk); scl = c; sda = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic cwr(input logic sta_v, input logic sto_v, input logic si_v, input logic aa_v);
    @(negedge clk); we = 1; w_sta = sta_v; w_sto = sto_v; w_si = si_v; w_aa = aa_v;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int n0;
    wait_n(3);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk("R10 status", {24'd0, status}, 32'hF8);
    chk("R10 rel", {30'd0, scl_rel, sda_rel}, 0);
    chk("R10 si", {31'd0, si_o}, 0);

    // R2 START in address phase as master
    mode = 2'd1; phase = 3'd1; step(1, 1, 4);
    step(1, 0, 5);
    chk("R2 si after START", {31'd0, si_o}, 1);
    chk("R2 status berr", {24'd0, status}, 32'h00);
    chk("R6 release held", {30'd0, scl_rel, sda_rel}, 3);
    // R6 STOP while pending is ignored
    step(1, 1, 5);
    chk("R6 still pending", {31'd0, scl_rel}, 1);
    // R8 writing SI=1 has no effect, STO set alone does not recover
    cwr(1, 0, 1, 1); wait_n(3);
    chk("R8 si kept", {31'd0, si_o}, 1);
    cwr(1, 1, 1, 1); wait_n(3);
    chk("R8 no recovery while si set", {31'd0, scl_rel}, 1);
    n0 = nas_cnt;
    cwr(1, 1, 0, 1); wait_n(3);
    chk("R7 sto cleared", {31'd0, sto_o}, 0);
    chk("R7 sta/aa kept", {30'd0, sta_o, aa_o}, 3);
    chk("R7 released dropped", {30'd0, scl_rel, sda_rel}, 0);
    chk("R7 one nas pulse", nas_cnt - n0, 1);
    chk("R1 status idle", {24'd0, status}, 32'hF8);

    // R2 STOP in data phase as addressed slave
    mode = 2'd2; phase = 3'd2;
    step(0, 1, 2); step(0, 0, 2); step(1, 0, 3);
    chk("R5 no event with scl low", {31'd0, si_o}, 0);
    step(1, 1, 5);
    chk("R2 si after STOP", {31'd0, si_o}, 1);
    cwr(0, 1, 0, 0); wait_n(3);
    chk("R7 recovered slave", {31'd0, scl_rel}, 0);

    // R2 START in acknowledge phase
    mode = 2'd1; phase = 3'd3; step(1, 1, 3);
    step(1, 0, 5);
    chk("R2 si in ack", {31'd0, si_o}, 1);
    // R8 clear SI without STO keeps error
    cwr(0, 0, 0, 1); wait_n(3);
    chk("R8 si cleared", {31'd0, si_o}, 0);
    chk("R8 still released", {30'd0, scl_rel, sda_rel}, 3);
    cwr(0, 1, 0, 1); wait_n(3);
    chk("R7 recovered after split writes", {31'd0, scl_rel}, 0);
    step(0, 0, 2); step(0, 1, 2); step(1, 1, 3);

    // R4 idle and waiting-for-repeated-START phases
    phase = 3'd0; step(1, 0, 4); step(1, 1, 4);
    chk("R4 idle legal", {31'd0, si_o}, 0);
    phase = 3'd4; step(1, 0, 4); step(1, 1, 4);
    chk("R4 wait_rs legal", {31'd0, si_o}, 0);

    // R3 non-addressed slave ignores conditions
    mode = 2'd0; phase = 3'd2; step(1, 0, 4); step(1, 1, 4);
    chk("R3 nas no error", {31'd0, si_o}, 0);

    // R5 SDA moves while SCL low, SCL toggles alone
    mode = 2'd1; phase = 3'd2;
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 2); step(0, 0, 2); step(0, 1, 2); step(1, 1, 2);
    end
    step(1, 1, 3);
    chk("R5 no false condition", {31'd0, si_o}, 0);

    // R9 STO outside error is held
    n0 = nas_cnt;
    cwr(0, 1, 0, 0); wait_n(6);
    chk("R9 sto held", {31'd0, sto_o}, 1);
    chk("R9 no release", {31'd0, scl_rel}, 0);
    chk("R9 no nas", nas_cnt - n0, 0);
    cwr(0, 0, 0, 0);

    // R10 reset during pending error
    phase = 3'd1; step(1, 0, 5);
    chk("R2 error before reset", {31'd0, si_o}, 1);
    @(negedge clk); rst = 1; wait_n(2); rst = 0;
    scl = 1; sda = 1; phase = 3'd0; wait_n(3);
    chk("R10 cleared by reset", {29'd0, si_o, scl_rel, sto_o}, 0);
    chk("R10 status after reset", {24'd0, status}, 32'hF8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule